// File: doc/BRIEF.md
# Multistage Cascaded Watchdog Timer

This block supervises a processor with a chain of timer stages. Only the first stage listens to the processor. A kick strobe puts that stage back to the start of its interval. If stage one runs out, it raises its corrective action and starts the second stage. Each later stage does the same when it runs out, and the processor cannot stop it. The stage at the end of the chain raises its own action and fires a fixed-length system reset pulse. When that pulse ends, the whole chain returns to idle, and stage one starts again if the watchdog is enabled.

Stage one's timeout gives a single-cycle non-maskable interrupt strobe. It also gives a fail-safe level that holds the plant outputs safe until the reset pulse completes. Each stage takes its interval from its own 2-bit select field, and the field is read at the moment that stage starts. A sticky status register records which stage timed out most recently. The watchdog's own reset pulse does not clear it; only power-on reset does. All pins are plain control and status signals, and none carries a data stream, so there is no valid/ready handshake.

Top module: `wdog_cascade`

## Requirements
- R1: A kick seen on a clock edge while stage one is counting, and not at its terminal count, restarts stage one. Stage one's action then rises exactly N0 edges after that kick edge, or after the start edge if no kick came. With the 2-bit select code c, N0 is the stage's interval.
- R2: When stage k (not the last) times out, stage_act_o[k] rises on that edge and stage k+1 starts on the same edge. stage_act_o[k+1] therefore rises exactly N(k+1) edges later.
- R3: Select code c of stage k is interval_sel[2k+1:2k]. It gives an interval of 2^(BASE_LOG2 + STEP_LOG2*c) cycles, which by default is 1024, 16384, 262144 or 4194304. The code is sampled when the stage starts.
- R4: Once stage one has timed out, kicks have no effect on any stage.
- R5: When the last stage times out, its action rises and sys_rst_o rises on the same edge, and no further stage starts.
- R6: sys_rst_o stays high for exactly PULSE_LEN cycles, 16 by default. On the edge where it falls, every stage action clears. If enable is high, stage one restarts on the next edge.
- R7: Stage one's timeout drives nmi_o high for exactly one cycle, on the edge where failsafe_o rises. failsafe_o then holds until the reset pulse ends.
- R8: A kick on the same edge at which stage one reaches its terminal count is ignored, and the timeout happens.
- R9: status_o reads 0 after power-on reset. It reads k+1 from the edge where stage k times out, and it keeps its value through the watchdog reset pulse.
- R10: While enable is low, stage one does not start, and a stage one that is counting returns to idle. After stage one has timed out, enable has no effect until the reset pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| enable | input | 1 | Allows stage one to run |
| kick | input | 1 | Restart strobe for stage one |
| interval_sel | input | NUM_STAGES*SEL_W | Per-stage interval codes, stage k in bits [SEL_W*k +: SEL_W] |
| nmi_o | output | 1 | One-cycle interrupt strobe on stage one timeout |
| failsafe_o | output | 1 | Fail-safe level from stage one timeout to reset-pulse end |
| stage_act_o | output | NUM_STAGES | Per-stage corrective-action levels |
| sys_rst_o | output | 1 | System reset pulse, PULSE_LEN cycles |
| status_o | output | $clog2(NUM_STAGES+1) | Sticky number of the last stage to time out, 0 for none |

## Verification
On every cycle, the assertions check four things: that the actions are ordered along the cascade, that the interrupt is a single cycle that coincides with fail-safe, that fail-safe holds until the reset pulse falls, and that the pulse is exactly PULSE_LEN cycles long and begins only with the last stage's action. The status code is also checked to be sticky and in range. The exact edge counts need the bench's scenarios. These are the interval arithmetic for every select combination, the restart point after a kick, the too-late kick at terminal count, kicks and enable being ignored in later stages, and the automatic restart after the pulse.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_RUN  = 2'd1,
    STG_DONE = 2'd2
  } stage_state_e;

  // log2 of a stage interval for a given select code
  function automatic int unsigned interval_log2(input int unsigned base_log2,
                                                input int unsigned step_log2,
                                                input int unsigned code);
    return base_log2 + step_log2 * code;
  endfunction

  // counter width able to hold the longest interval minus one
  function automatic int unsigned count_width(input int unsigned base_log2,
                                              input int unsigned step_log2,
                                              input int unsigned sel_w);
    return base_log2 + step_log2 * ((1 << sel_w) - 1);
  endfunction

endpackage

// File: rtl/wdog_stage.sv
`timescale 1ns/1ps
module wdog_stage
  import wdog_pkg::*;
#(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned STEP_LOG2 = 4,
  parameter int unsigned CNT_W     = 22,
  parameter bit          KICKABLE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic             halt,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel,
  output logic             tmo_o,
  output logic             act_o,
  output logic             busy_o
);

  stage_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;
  logic             terminal;
  int unsigned      shamt;

  // limit = interval - 1; the widest code wraps 1<<CNT_W to 0, giving all ones
  always_comb begin
    shamt = interval_log2(BASE_LOG2, STEP_LOG2, int'(sel));
    lim_d = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  assign terminal = (state_q == STG_RUN) && (cnt_q == lim_q);
  assign tmo_o    = terminal;
  assign busy_o   = (state_q != STG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STG_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      act_o   <= 1'b0;
    end else if (clear) begin
      state_q <= STG_IDLE;
      cnt_q   <= '0;
      act_o   <= 1'b0;
    end else begin
      unique case (state_q)
        STG_IDLE: begin
          if (start) begin
            state_q <= STG_RUN;
            cnt_q   <= '0;
            lim_q   <= lim_d;
          end
        end
        STG_RUN: begin
          if (terminal) begin
            // terminal count wins over a same-cycle kick or halt
            state_q <= STG_DONE;
            act_o   <= 1'b1;
          end else if (halt) begin
            state_q <= STG_IDLE;
            cnt_q   <= '0;
          end else if (KICKABLE && kick) begin
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          // STG_DONE: wait for the cascade clear
        end
      endcase
    end
  end

endmodule

// File: rtl/wdog_rst_pulse.sv
`timescale 1ns/1ps
module wdog_rst_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o,
  output logic done_o
);

  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign pulse_o = active_q;
  assign done_o  = active_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (fire) begin
        active_q <= 1'b1;
        cnt_q    <= CW'(PULSE_LEN - 1);
      end
    end else if (cnt_q == '0) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/wdog_status.sv
`timescale 1ns/1ps
module wdog_status #(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned STG_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] tmo,
  output logic [STG_W-1:0]      code_o
);

  logic [STG_W-1:0] code_d;
  logic             hit;

  always_comb begin
    code_d = '0;
    hit    = 1'b0;
    for (int k = 0; k < int'(NUM_STAGES); k++) begin
      if (tmo[k]) begin
        code_d = STG_W'(k + 1);
        hit    = 1'b1;
      end
    end
  end

  // power-on reset only: the watchdog pulse does not reach this register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
    end else if (hit) begin
      code_o <= code_d;
    end
  end

endmodule

// File: rtl/wdog_cascade.sv
`timescale 1ns/1ps
module wdog_cascade
  import wdog_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned BASE_LOG2  = 10,
  parameter int unsigned STEP_LOG2  = 4,
  parameter int unsigned PULSE_LEN  = 16,
  localparam int unsigned STG_W     = $clog2(NUM_STAGES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        kick,
  input  logic [NUM_STAGES*SEL_W-1:0] interval_sel,
  output logic                        nmi_o,
  output logic                        failsafe_o,
  output logic [NUM_STAGES-1:0]       stage_act_o,
  output logic                        sys_rst_o,
  output logic [STG_W-1:0]            status_o
);

  localparam int unsigned CNT_W = count_width(BASE_LOG2, STEP_LOG2, SEL_W);

  logic [NUM_STAGES-1:0] tmo;
  logic [NUM_STAGES-1:0] act;
  logic [NUM_STAGES-1:0] busy;
  logic                  pulse_active;
  logic                  pulse_done;
  logic                  cascade_busy;
  logic                  nmi_q;

  assign cascade_busy = (|busy) | pulse_active;

  for (genvar k = 0; k < int'(NUM_STAGES); k++) begin : g_stage
    logic start_k;
    logic kick_k;
    logic halt_k;

    if (k == 0) begin : g_head
      assign start_k = enable & ~cascade_busy;
      assign kick_k  = kick;
      assign halt_k  = ~enable;
    end else begin : g_tail
      assign start_k = tmo[k-1];
      assign kick_k  = 1'b0;
      assign halt_k  = 1'b0;
    end

    wdog_stage #(
      .SEL_W     (SEL_W),
      .BASE_LOG2 (BASE_LOG2),
      .STEP_LOG2 (STEP_LOG2),
      .CNT_W     (CNT_W),
      .KICKABLE  (k == 0)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (pulse_done),
      .start  (start_k),
      .halt   (halt_k),
      .kick   (kick_k),
      .sel    (interval_sel[k*SEL_W +: SEL_W]),
      .tmo_o  (tmo[k]),
      .act_o  (act[k]),
      .busy_o (busy[k])
    );
  end

  wdog_rst_pulse #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (tmo[NUM_STAGES-1]),
    .pulse_o (pulse_active),
    .done_o  (pulse_done)
  );

  wdog_status #(
    .NUM_STAGES (NUM_STAGES),
    .STG_W      (STG_W)
  ) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .tmo    (tmo),
    .code_o (status_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
    end else begin
      nmi_q <= tmo[0];
    end
  end

  assign nmi_o       = nmi_q;
  assign failsafe_o  = act[0];
  assign stage_act_o = act;
  assign sys_rst_o   = pulse_active;

endmodule

// File: rtl/wdog_cascade_chk.sv
`timescale 1ns/1ps
module wdog_cascade_chk #(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned PULSE_LEN  = 16,
  parameter int unsigned STG_W      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  nmi_o,
  input logic                  failsafe_o,
  input logic [NUM_STAGES-1:0] stage_act_o,
  input logic                  sys_rst_o,
  input logic [STG_W-1:0]      status_o
);

  localparam int unsigned HW = $clog2(PULSE_LEN + 2);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (sys_rst_o) hi_cnt <= hi_cnt + HW'(1);
    else                hi_cnt <= '0;
  end

  for (genvar k = 1; k < int'(NUM_STAGES); k++) begin : g_order
    AST_CASCADE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage_act_o[k]) |-> stage_act_o[k-1]); // R2
  end

  AST_PULSE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $rose(stage_act_o[NUM_STAGES-1])); // R5
  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (hi_cnt < HW'(PULSE_LEN))); // R6
  AST_PULSE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> ($past(hi_cnt) == HW'(PULSE_LEN - 1))); // R6
  AST_ACT_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(failsafe_o) |-> $fell(sys_rst_o)); // R6
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o); // R7
  AST_NMI_WITH_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failsafe_o) |-> nmi_o); // R7
  AST_FAILSAFE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (failsafe_o && !sys_rst_o) |=> failsafe_o); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != '0) |=> (status_o != '0)); // R9
  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    status_o <= STG_W'(NUM_STAGES)); // R9

endmodule

bind wdog_cascade wdog_cascade_chk #(
  .NUM_STAGES (NUM_STAGES),
  .PULSE_LEN  (PULSE_LEN),
  .STG_W      ($clog2(NUM_STAGES + 1))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi_o       (nmi_o),
  .failsafe_o  (failsafe_o),
  .stage_act_o (stage_act_o),
  .sys_rst_o   (sys_rst_o),
  .status_o    (status_o)
);

// File: tb/wdog_cascade_tb.sv
`timescale 1ns/1ps
module wdog_cascade_tb;

  localparam int NS = 3;
  localparam int SW = 2;
  localparam int BL = 3;
  localparam int SL = 1;
  localparam int PL = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          enable;
  logic          kick;
  logic [NS*SW-1:0] sel;
  logic          nmi;
  logic          fs;
  logic [NS-1:0] act;
  logic          sys_rst;
  logic [1:0]    status;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  wdog_cascade #(
    .NUM_STAGES (NS), .SEL_W (SW), .BASE_LOG2 (BL), .STEP_LOG2 (SL), .PULSE_LEN (PL)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .enable (enable), .kick (kick),
    .interval_sel (sel), .nmi_o (nmi), .failsafe_o (fs),
    .stage_act_o (act), .sys_rst_o (sys_rst), .status_o (status)
  );

  function automatic int ncyc(input int code);
    return 1 << (BL + SL * code);
  endfunction

  task automatic chk_eq(input string req, input int a, input int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic por(input logic [NS*SW-1:0] s, input logic en);
    rst_n = 1'b0; kick = 1'b0; sel = s; enable = en;
    repeat (3) step();
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic wait_fs(input int limit);
    while (!fs && cyc < limit) step();
  endtask

  // full cascade timing for one select combination
  task automatic run_combo(input logic [5:0] s);
    int n0 = ncyc(int'(s[1:0]));
    int n1 = ncyc(int'(s[3:2]));
    int n2 = ncyc(int'(s[5:4]));
    int total = n0 + n1 + n2;
    int t_fs = -1, t_a1 = -1, t_a2 = -1, t_rs = -1, t_rf = -1, t_n2 = -1;
    int nmi_cnt = 0, st_fs = -1, st_rf = -1, act_rf = -1;
    logic p_rst = 1'b0, p_nmi = 1'b0;
    por(s, 1'b1);
    for (int c = 1; c <= total + PL + n0 + 4; c++) begin
      step();
      if (fs && t_fs < 0) begin t_fs = c; st_fs = int'(status); end
      if (act[1] && t_a1 < 0) t_a1 = c;
      if (act[2] && t_a2 < 0) t_a2 = c;
      if (sys_rst && !p_rst && t_rs < 0) t_rs = c;
      if (!sys_rst && p_rst && t_rf < 0) begin t_rf = c; st_rf = int'(status); act_rf = int'(act); end
      if (nmi && !p_nmi && t_rf >= 0 && t_n2 < 0) t_n2 = c;
      if (nmi && t_rs < 0) nmi_cnt++;
      p_rst = sys_rst; p_nmi = nmi;
    end
    chk_eq("R3 stage one interval from code", t_fs, 1 + n0);
    chk_eq("R2 stage two action after its interval", t_a1, 1 + n0 + n1);
    chk_eq("R5 reset pulse start", t_rs, 1 + total);
    chk_eq("R5 last action with pulse", t_a2, t_rs);
    chk_eq("R6 pulse length", t_rf - t_rs, PL);
    chk_eq("R6 actions cleared at pulse end", act_rf, 0);
    chk_eq("R6 automatic restart of stage one", t_n2, t_rf + 1 + n0);
    chk_eq("R7 nmi single cycle", nmi_cnt, 1);
    chk_eq("R9 status after stage one", st_fs, 1);
    chk_eq("R9 status kept through pulse", st_rf, 3);
  endtask

  initial begin
    int last_kick;
    bit seen;
    int t_a1, t_rs;

    // reset state
    por(6'd0, 1'b1);
    chk_eq("R9 reset status", int'(status), 0);
    chk_eq("R7 reset failsafe", int'(fs), 0);
    chk_eq("R6 reset pulse low", int'(sys_rst), 0);
    chk_eq("R2 reset actions", int'(act), 0);

    // sweep every select combination
    for (int s = 0; s < 64; s++) run_combo(6'(s));

    // R1: periodic kicks hold stage one, then timeout N0 after last kick
    por(6'd0, 1'b1);
    seen = 1'b0; last_kick = 0;
    for (int i = 0; i < 20; i++) begin
      repeat (4) begin step(); if (fs) seen = 1'b1; end
      kick = 1'b1; step(); kick = 1'b0;
      if (fs) seen = 1'b1;
      last_kick = cyc;
    end
    chk_eq("R1 kicks prevent timeout", int'(seen), 0);
    wait_fs(last_kick + 50);
    chk_eq("R1 timeout after last kick", cyc, last_kick + 8);

    // R8: kick on the terminal edge is too late
    por(6'd0, 1'b1);
    repeat (8) step();
    kick = 1'b1; step(); kick = 1'b0;
    chk_eq("R8 late kick ignored", int'(fs), 1);
    chk_eq("R8 late kick nmi", int'(nmi), 1);

    // R1: kick one edge before terminal restarts the interval
    por(6'd0, 1'b1);
    repeat (7) step();
    kick = 1'b1; step(); kick = 1'b0;
    wait_fs(60);
    chk_eq("R1 kick before terminal restarts", cyc, 16);

    // R4 and R10: kick held and enable dropped after stage one timeout
    por(6'd0, 1'b1);
    repeat (9) step();
    chk_eq("R4 stage one timed out", int'(fs), 1);
    kick = 1'b1; enable = 1'b0;
    t_a1 = -1; t_rs = -1;
    for (int c = 10; c <= 30; c++) begin
      step();
      if (act[1] && t_a1 < 0) t_a1 = c;
      if (sys_rst && t_rs < 0) t_rs = c;
    end
    chk_eq("R4 kicks ignored in stage two", t_a1, 17);
    chk_eq("R10 enable ignored after timeout", t_rs, 25);
    kick = 1'b0; enable = 1'b1;

    // R10: disabled watchdog stays idle, enabling starts stage one
    por(6'd0, 1'b0);
    seen = 1'b0;
    repeat (100) begin step(); if (fs || sys_rst || status != 2'd0) seen = 1'b1; end
    chk_eq("R10 disabled stays idle", int'(seen), 0);
    enable = 1'b1;
    wait_fs(200);
    chk_eq("R10 enable starts stage one", cyc, 109);

    // R10: dropping enable while stage one counts stops it
    por(6'd0, 1'b1);
    repeat (4) step();
    enable = 1'b0;
    seen = 1'b0;
    repeat (40) begin step(); if (fs) seen = 1'b1; end
    chk_eq("R10 disable stops stage one", int'(seen), 0);
    enable = 1'b1;
    wait_fs(200);
    chk_eq("R10 re-enable restarts full interval", cyc, 53);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule